// File: doc/BRIEF.md
# Single-Wire Pulse-Width LED Data Receiver

This block sits at the receiving end of a single-wire LED data chain and recovers pixel words in the same way a chained pixel would. The line idles low. Every bit starts with a rising edge, and the bit value is carried by how long the line then stays high. The receiver does not time the whole bit period. Instead, each rising edge starts a one-shot timer, and the line level at the moment the timer runs out is taken as the bit. A short high pulse has already dropped by then and reads as zero. A long high pulse is still up and reads as one. Because the low time after a bit is never measured, jitter in that low phase does not matter.

Bits are gathered most significant first into 24-bit words. Each completed word is presented for one cycle together with its position in the current frame. If the line stays low for longer than a configurable threshold, the receiver treats this as a frame reset. It drops any partly received word, restarts the word position at zero and raises a frame-start pulse. The clock frequency, the sample delay and the reset threshold are parameters, and the receiver converts them to cycle counts at elaboration.

Top module: `ledrx_top`

## Requirements
- R1: The input passes through a two-flop synchronizer. Each rising edge of the synchronized line starts a one-shot timer of SAMPLE_NS (rounded to clock cycles). When the timer expires, the synchronized line level is taken as the received bit.
- R2: A high pulse noticeably shorter than the sample delay decodes as 0, and a high pulse noticeably longer decodes as 1. With the default 580 ns delay, a 496 ns high gives 0 and a 624 ns high gives 1.
- R3: Bits fill a word most significant bit first. After 24 bits, `word_o` shows the word (the first bit received lands in bit 23) and `word_vld_o` is high for exactly one cycle.
- R4: A rising edge that arrives while the sample timer is still running is ignored. It neither restarts the timer nor produces an extra bit.
- R5: When the synchronized line has been low for RESET_NS (rounded to clock cycles), `frame_start_o` pulses high for one cycle. It pulses only once per low stretch, however long the stretch lasts. This includes the idle-low line after reset.
- R6: A frame reset discards any partly assembled word, so the next word is built only from bits received after the reset.
- R7: `word_idx_o` gives each valid word's position within the frame: 0 for the first word after a frame start, then counting up by one. Low gaps shorter than the threshold do not reset it.
- R8: While `rst_n` is low and just after it is released, `word_vld_o` and `frame_start_o` are low and `word_o` and `word_idx_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 1 | Asynchronous serial LED data line |
| word_o | output | 24 (WORD_BITS) | Last completed word, first bit received in the MSB |
| word_vld_o | output | 1 | One-cycle pulse marking a new word on `word_o` |
| word_idx_o | output | 8 (IDX_W) | Position of the word within the current frame |
| frame_start_o | output | 1 | One-cycle pulse on a long low (frame reset) |

## Verification
The bench builds the receiver with a 125 MHz clock, a 580 ns sample delay (72 cycles) and a 10 µs reset threshold (1250 cycles) instead of the 50 µs default. The shorter threshold brings several frame resets and a partial-word discard within a short run. It also allows a low gap of 1000 cycles, just under the threshold, to show that the word index keeps counting. Pulse widths of 62 and 78 cycles sit close to both sides of the 72-cycle sample point. A high–low–high pattern inside one sample window exercises the rule that a second edge during the window is ignored.

// File: rtl/ledrx_pkg.sv
package ledrx_pkg;

    // Convert a duration in ns to a clock cycle count, never below 2.
    function automatic int ns_to_cycles(input int clk_mhz, input int dur_ns);
        int c;
        c = (clk_mhz * dur_ns) / 1000;
        if (c < 2) c = 2;
        return c;
    endfunction

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/ledrx_sync.sv
module ledrx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic line_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = din_i;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_o = q.s2;
    assign rise_o = q.s2 & ~q.prev;

    // R1: a rising edge is a single-cycle event
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ledrx_sample_timer.sv
module ledrx_sample_timer
    import ledrx_pkg::*;
#(
    parameter int SAMPLE_CYC = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic rise_i,
    output logic smp_stb_o,
    output logic smp_bit_o
);
    localparam int CW = $clog2(SAMPLE_CYC + 1);

    typedef struct packed {
        tmr_state_e st;
        logic [CW-1:0] cnt;
        logic stb;
        logic bit_v;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        case (q.st)
            TMR_IDLE: begin
                if (rise_i) begin
                    d.st  = TMR_RUN;
                    d.cnt = CW'(SAMPLE_CYC - 1);
                end
            end
            default: begin
                if (q.cnt == '0) begin
                    d.st    = TMR_IDLE;
                    d.stb   = 1'b1;
                    d.bit_v = line_i;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: TMR_IDLE, cnt: '0, stb: 1'b0, bit_v: 1'b0};
        else        q <= d;
    end

    assign smp_stb_o = q.stb;
    assign smp_bit_o = q.bit_v;

    // R4: an edge during a running window does not reload the timer
    assert_edge_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TMR_RUN && q.cnt != '0 && rise_i) |=> (q.cnt == $past(q.cnt) - CW'(1)));

    // R1: one sample per window
    assert_sample_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_o |=> !smp_stb_o);

endmodule

// File: rtl/ledrx_idle_det.sv
module ledrx_idle_det #(
    parameter int RESET_CYC = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic frame_o
);
    localparam int CW = $clog2(RESET_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic armed;
        logic pulse;
    } idle_t;

    idle_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (line_i) begin
            d.cnt   = '0;
            d.armed = 1'b1;
        end else if (q.armed) begin
            if (q.cnt == CW'(RESET_CYC - 1)) begin
                d.pulse = 1'b1;
                d.armed = 1'b0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cnt: '0, armed: 1'b1, pulse: 1'b0};
        else        q <= d;
    end

    assign frame_o = q.pulse;

    // R5: one pulse per low stretch
    assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);

    // R5: a pulse only follows a low line
    assert_pulse_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> $past(!line_i));

endmodule

// File: rtl/ledrx_top.sv
module ledrx_top
    import ledrx_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int SAMPLE_NS = 580,
    parameter int RESET_NS  = 50000,
    parameter int WORD_BITS = 24,
    parameter int IDX_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_vld_o,
    output logic [IDX_W-1:0]     word_idx_o,
    output logic                 frame_start_o
);
    localparam int SAMPLE_CYC = ns_to_cycles(CLK_MHZ, SAMPLE_NS);
    localparam int RESET_CYC  = ns_to_cycles(CLK_MHZ, RESET_NS);
    localparam int BCW        = $clog2(WORD_BITS);

    logic line, rise, smp_stb, smp_bit, frame_pulse;

    ledrx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (din_i),
        .line_o(line),
        .rise_o(rise)
    );

    ledrx_sample_timer #(.SAMPLE_CYC(SAMPLE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line),
        .rise_i   (rise),
        .smp_stb_o(smp_stb),
        .smp_bit_o(smp_bit)
    );

    ledrx_idle_det #(.RESET_CYC(RESET_CYC)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line),
        .frame_o(frame_pulse)
    );

    typedef struct packed {
        logic [WORD_BITS-1:0] shreg;
        logic [BCW-1:0]       bcnt;
        logic [WORD_BITS-1:0] word;
        logic                 vld;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     nidx;
        logic                 fs;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.fs  = 1'b0;
        if (frame_pulse) begin
            d.shreg = '0;
            d.bcnt  = '0;
            d.nidx  = '0;
            d.fs    = 1'b1;
        end else if (smp_stb) begin
            d.shreg = {q.shreg[WORD_BITS-2:0], smp_bit};
            if (q.bcnt == BCW'(WORD_BITS - 1)) begin
                d.word = {q.shreg[WORD_BITS-2:0], smp_bit};
                d.vld  = 1'b1;
                d.idx  = q.nidx;
                d.nidx = q.nidx + IDX_W'(1);
                d.bcnt = '0;
            end else begin
                d.bcnt = q.bcnt + BCW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o        = q.word;
    assign word_vld_o    = q.vld;
    assign word_idx_o    = q.idx;
    assign frame_start_o = q.fs;

    // R3: a valid word is a one-cycle pulse
    assert_word_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R3: the bit counter stays within a word
    assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.bcnt < BCW'(WORD_BITS));

    // R6: a frame start and a word never complete together
    assert_frame_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> !word_vld_o);

    // R7: the reported index holds between words
    assert_idx_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_idx_o));

endmodule

// File: tb/ledrx_top_bench.sv
module ledrx_top_bench;
    localparam int WB = 24;
    localparam int IW = 8;
    localparam int BIT_CYC = 156;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic [WB-1:0] word;
    logic vld, fs;
    logic [IW-1:0] idx;

    int checks = 0;
    int fails  = 0;
    int fs_cnt = 0;
    int cycles = 0;
    bit done   = 1'b0;
    logic [WB+IW-1:0] expq[$];

    always #4 clk = ~clk;

    ledrx_top #(
        .CLK_MHZ(125), .SAMPLE_NS(580), .RESET_NS(10000),
        .WORD_BITS(WB), .IDX_W(IW)
    ) u_ledrx_top (
        .clk(clk), .rst_n(rst_n), .din_i(din),
        .word_o(word), .word_vld_o(vld), .word_idx_o(idx), .frame_start_o(fs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && vld) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6 unexpected word", {8'h0, word}, 0);
            end else begin
                logic [WB+IW-1:0] e;
                e = expq.pop_front();
                check(word == e[WB+IW-1:IW], "R1/R2/R3 word", {8'h0, word}, {8'h0, e[WB+IW-1:IW]});
                check(idx == e[IW-1:0], "R7 index", {24'h0, idx}, {24'h0, e[IW-1:0]});
            end
        end
        if (rst_n && fs) fs_cnt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input int hi);
        @(negedge clk);
        din = 1'b1;
        idle(hi);
        din = 1'b0;
        idle(BIT_CYC - hi);
    endtask

    task automatic send_word(input logic [WB-1:0] w, input logic [IW-1:0] i,
                             input int hi0, input int hi1);
        expq.push_back({w, i});
        for (int k = WB - 1; k >= 0; k--) send_bit(w[k], w[k] ? hi1 : hi0);
    endtask

    initial begin
        idle(5);
        // R8: reset state
        check(vld == 1'b0 && fs == 1'b0 && word == '0 && idx == '0, "R8 reset", {vld, fs}, 0);
        rst_n = 1'b1;
        idle(2);
        check(vld == 1'b0 && fs == 1'b0 && word == '0 && idx == '0, "R8 after reset", {vld, fs}, 0);

        // R5: idle low after reset yields one frame start
        idle(1400);
        check(fs_cnt == 1, "R5 power-up frame", fs_cnt, 1);

        // R7: words separated by a sub-threshold gap keep counting
        send_word(24'hA5C30F, 8'd0, 40, 100);
        idle(1000);
        send_word(24'h3C96E1, 8'd1, 40, 100);
        check(fs_cnt == 1, "R7 short gap no frame", fs_cnt, 1);

        // R2: boundary pulse widths
        send_word(24'hF0F00F, 8'd2, 62, 78);
        send_word(24'h000000, 8'd3, 62, 78);
        send_word(24'hFFFFFF, 8'd4, 62, 78);

        // R6: partial word then long low
        for (int k = 0; k < 10; k++) send_bit(1'b1, 100);
        idle(1400);
        check(fs_cnt == 2, "R5 frame after partial", fs_cnt, 2);
        send_word(24'h81422C, 8'd0, 40, 100);

        // R4: second edge inside the sample window is ignored
        expq.push_back({24'h012345, 8'd1});
        for (int k = WB - 1; k >= 1; k--) send_bit(24'h012345 >> k & 1, (24'h012345 >> k & 1) ? 100 : 40);
        @(negedge clk);
        din = 1'b1; idle(40);
        din = 1'b0; idle(10);
        din = 1'b1; idle(40);
        din = 1'b0; idle(66);

        // R5: one pulse per low stretch, however long
        idle(1400);
        check(fs_cnt == 3, "R5 frame after words", fs_cnt, 3);
        idle(2800);
        check(fs_cnt == 3, "R5 single pulse per stretch", fs_cnt, 3);
        check(expq.size() == 0, "R3 all words received", expq.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule